// File: doc/BRIEF.md
# Masked-Write Output Port

This block is a general-purpose output port of parameterised width `WIDTH` (32 by default), driven from a simple memory-mapped write/read bus. Software can replace the whole port in one write through a data register. It can also update any chosen subset of pins in a single write through a mask/value register, so every selected pin changes on the same clock edge. A read-modify-write sequence is not needed.

The mask/value register packs a mask into its upper half and the new pin levels into its lower half, so one access covers only `WIDTH/2` pins. A one-bit window register chooses whether those pins are the lower or the upper half of the port. Unselected pins, and pins whose mask bit is clear, keep their level.

Top module: `gpio_masked_port`

## Requirements
- R1: After reset all outputs on `pins_out` are low and the window register holds 0.
- R2: A write to address 0 replaces all `WIDTH` pins with `bus_wdata` on the next clock edge. A read of address 0 returns the current pin levels in the same cycle.
- R3: In a write to address 1, bits [WIDTH-1:WIDTH/2] of `bus_wdata` form the mask and bits [WIDTH/2-1:0] form the values. Mask bit i pairs with value bit i.
- R4: In a write to address 1, each pin whose mask bit is 1 takes its value bit on the next edge, with all such pins changing on that single edge. Each pin whose mask bit is 0 keeps its level.
- R5: With the window at 0, mask bit i acts on pin i. With the window at 1, it acts on pin i+WIDTH/2. Pins outside the chosen half are unchanged by a write to address 1.
- R6: A write to address 2 loads the window from bit 0 of `bus_wdata`, and its other bits are ignored. A read of address 2 returns the window in bit 0 with zeros elsewhere.
- R7: A read of address 1 returns zero.
- R8: A write to address 3 changes neither the pins nor the window. A read of address 3 returns zero.
- R9: In a cycle without a write, the pins hold their levels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 2 | Register address: 0 data, 1 mask/value, 2 window, 3 unused |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data for `bus_addr`, same cycle |
| pins_out | output | WIDTH | Output pin levels |

## Verification
The bench targets several corner cases.

- Mask/value writes with a sparse mask: a design that ignored the mask would also overwrite pins whose mask bit is clear.
- Writes made with the window at 1: a design that missed the offset would disturb the lower half instead of the upper one.
- Swapped mask and value halves: this is exposed by a write whose mask and value differ.
- Window writes with junk in the upper bits, and writes to the unused address: these catch a decoder that lets stray bits or addresses through.
- Long random runs that mix all four addresses: a stale or misordered update would make the pins differ from the behavioural model within a cycle.

// File: rtl/gpio_masked_port.sv
module gpio_masked_port #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  output logic [WIDTH-1:0] pins_out
);
  localparam int HALF = WIDTH / 2;
  localparam logic [1:0] A_DATA = 2'd0, A_MVAL = 2'd1, A_WIN = 2'd2;

  logic             win;
  logic [HALF-1:0]  mv_mask, mv_val;
  logic [WIDTH-1:0] wide_mask, wide_val, pins_next;

  assign mv_mask   = bus_wdata[WIDTH-1:HALF];
  assign mv_val    = bus_wdata[HALF-1:0];
  assign wide_mask = win ? {mv_mask, {HALF{1'b0}}} : {{HALF{1'b0}}, mv_mask};
  assign wide_val  = win ? {mv_val,  {HALF{1'b0}}} : {{HALF{1'b0}}, mv_val};

  always_comb begin
    pins_next = pins_out;
    if (bus_wr && bus_addr == A_DATA) pins_next = bus_wdata;
    else if (bus_wr && bus_addr == A_MVAL)
      pins_next = (pins_out & ~wide_mask) | (wide_val & wide_mask);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pins_out <= '0;
      win      <= 1'b0;
    end else begin
      pins_out <= pins_next;
      if (bus_wr && bus_addr == A_WIN) win <= bus_wdata[0];
    end
  end

  always_comb begin
    case (bus_addr)
      A_DATA:  bus_rdata = pins_out;
      A_WIN:   bus_rdata = {{(WIDTH-1){1'b0}}, win};
      default: bus_rdata = '0;
    endcase
  end

  assert_reset_low_R1: assert property (@(posedge clk)
    !rst_n |=> pins_out == '0);

  assert_data_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == A_DATA |=> pins_out == $past(bus_wdata));

  assert_low_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == A_MVAL && !win |=>
      pins_out[WIDTH-1:HALF] == $past(pins_out[WIDTH-1:HALF]) &&
      (pins_out[HALF-1:0] & $past(bus_wdata[WIDTH-1:HALF])) ==
      ($past(bus_wdata[HALF-1:0]) & $past(bus_wdata[WIDTH-1:HALF])));

  assert_high_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == A_MVAL && win |=>
      pins_out[HALF-1:0] == $past(pins_out[HALF-1:0]) &&
      ((pins_out[WIDTH-1:HALF] ^ $past(pins_out[WIDTH-1:HALF])) &
       ~$past(bus_wdata[WIDTH-1:HALF])) == '0);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(pins_out));

  assert_unused_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == 2'd3 |=> $stable(pins_out));
endmodule

// File: tb/tb_gpio_masked_port.sv
module tb_gpio_masked_port;
  localparam int W = 32;
  localparam int H = W / 2;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 0, rst_n = 0, bus_wr = 0;
  logic [1:0] bus_addr = 0;
  logic [W-1:0] bus_wdata = 0, bus_rdata, pins_out;

  gpio_masked_port #(.WIDTH(W)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  logic [W-1:0] ref_pins = 0;
  logic ref_win = 0;
  string pin_tag = "R1";
  bit done = 0;

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic op(bit wr, logic [1:0] a, logic [W-1:0] d);
    logic [W-1:0] rexp;
    @(negedge clk);
    check({pin_tag, " pins"}, pins_out, ref_pins);
    bus_wr = wr; bus_addr = a; bus_wdata = d;
    #1;
    case (a)
      2'd0: rexp = ref_pins;
      2'd2: rexp = {{(W-1){1'b0}}, ref_win};
      default: rexp = '0;
    endcase
    check(a == 0 ? "R2 read" : a == 1 ? "R7 read" : a == 2 ? "R6 read" : "R8 read",
          bus_rdata, rexp);
    @(posedge clk);
    if (!wr) pin_tag = "R9";
    else case (a)
      2'd0: begin ref_pins = d; pin_tag = "R2"; end
      2'd1: begin
        for (int i = 0; i < H; i++)
          if (d[H+i]) ref_pins[i + (ref_win ? H : 0)] = d[i];
        pin_tag = ref_win ? "R5" : "R4";
      end
      2'd2: begin ref_win = d[0]; pin_tag = "R6"; end
      default: pin_tag = "R8";
    endcase
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1: reset state
    op(0, 2'd0, 0);
    op(0, 2'd2, 0);
    op(1, 2'd0, 32'hA5A5_0F0F);            // R2
    op(1, 2'd1, 32'h00FF_1234);            // R3/R4: mask low byte, values 0x34
    op(1, 2'd1, 32'hF000_0000);            // R4: clear pins 15:12
    op(1, 2'd2, 32'hFFFF_FFF1);            // R6: junk bits ignored
    op(0, 2'd2, 0);
    op(1, 2'd1, 32'h8001_0001);            // R5: pin 16 -> 1, pin 31 -> 0
    op(1, 2'd1, 32'hFFFF_5555);            // R5: upper half = 0x5555
    op(0, 2'd1, 0);                        // R7
    op(1, 2'd3, 32'hFFFF_FFFF);            // R8
    op(1, 2'd2, 32'h0000_0000);
    op(1, 2'd1, 32'h0000_FFFF);            // R4: mask zero, nothing moves
    op(0, 2'd0, 32'hFFFF_FFFF);            // R9
    for (int n = 0; n < 400; n++)
      op($urandom_range(0, 3) != 0, 2'($urandom_range(0, 3)), $urandom);
    op(0, 2'd0, 0);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule